// File: doc/BRIEF.md
# NAK Retry Timeout Monitor

This block watches a host controller's queue of pending transactions and raises an interrupt when retries of NAK-ed transactions have gone on longer than a programmed limit. Software programs an 8-bit limit in milliseconds. The block counts pulses of a 1 ms tick while a transfer is active and no transfer has completed. When the count reaches the limit, it sets a sticky timeout flag that drives the interrupt output.

Any completion restarts the count. A completion is a bit of the done map going from 0 to 1. A write to the limit register also restarts the count. The flag can only be raised while the whole done map is zero. A limit of zero switches the feature off. Software clears the flag by writing a 1 to it.

Two 16-bit registers are reachable through a simple write port and a combinational read port:
- Address 0: the limit register.
- Address 1: the status register.

Top module: `nak_watchdog`

## Requirements
- R1: After reset, the limit register (address 0) reads 0x0001, the status register (address 1) reads 0x0000, and `irq` is 0.
- R2: A write to address 0 stores `wr_data[7:0]` as the limit. Bits 15..8 are reserved: they are ignored on write and read back as 0.
- R3: The count advances only on a cycle where `tick_1ms`, `xfer_active` and an all-zero `done_map` hold together. The flag sets on the clock edge that samples the limit-th such cycle, counted from the last restart.
- R4: The flag never sets while `done_map` is not all zero; ticks in that state do not advance the count.
- R5: A limit of 0 disables the feature: no number of ticks sets the flag.
- R6: Any `done_map` bit going from 0 to 1 restarts the count from zero.
- R7: A write to the limit register restarts the count from zero. This holds even when the write and a qualifying tick fall in the same cycle.
- R8: The flag is bit 0 of the status register and is sticky. Writing 1 to bit 0 at address 1 clears it, and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins. `irq` always equals the flag.
- R9: After firing, the count saturates at the limit. No further firing happens until a restart, even if the flag is cleared and ticks continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 limit, 1 status |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register (combinational) |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| done_map | input | 32 | Per-slot completion flags |
| xfer_active | input | 1 | At least one transfer is queued and active |
| irq | output | 1 | Timeout interrupt (status flag) |

## Verification
Several properties are checked on every cycle:
- The flag stays set unless a clear is written.
- The flag cannot rise without a qualifying tick.
- The flag cannot rise with a non-zero done map or a zero limit.
- The count never exceeds the limit.
- The reserved read bits stay zero.

The exact firing cycle over a sweep of limit values only shows in the bench's scenarios. The same holds for restarts on completions and on register writes, for the set-over-clear priority, and for the saturation after firing.

// File: rtl/nak_wd_pkg.sv
package nak_wd_pkg;
    localparam int DATA_W  = 16;
    localparam int LIMIT_W = 8;
    localparam int MAP_W   = 32;
    localparam logic [LIMIT_W-1:0] LIMIT_RST = 8'd1;

    typedef enum logic {
        SEL_LIMIT  = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;

    localparam int FLAG_BIT = 0;
endpackage

// File: rtl/nak_wd_regs.sv
module nak_wd_regs
    import nak_wd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LIMIT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wr_data,
    input  logic          fire,
    output logic [DW-1:0] rd_data,
    output logic [LW-1:0] limit,
    output logic          limit_wr,
    output logic          flag
);
    typedef struct packed {
        logic [LW-1:0] limit;
        logic          flag;
    } regs_t;

    regs_t st_d, st_q;
    logic  clr;

    always_comb begin
        st_d     = st_q;
        limit_wr = wr_en && (reg_sel_e'(addr) == SEL_LIMIT);
        clr      = wr_en && (reg_sel_e'(addr) == SEL_STATUS) && wr_data[FLAG_BIT];
        if (limit_wr)
            st_d.limit = wr_data[LW-1:0];
        if (fire)
            st_d.flag = 1'b1;
        else if (clr)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.limit <= LW'(LIMIT_RST);
            st_q.flag  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (reg_sel_e'(addr) == SEL_LIMIT)
            rd_data[LW-1:0] = st_q.limit;
        else
            rd_data[FLAG_BIT] = st_q.flag;
    end

    assign limit = st_q.limit;
    assign flag  = st_q.flag;
endmodule

// File: rtl/nak_wd_counter.sv
module nak_wd_counter
    import nak_wd_pkg::*;
#(
    parameter int LW = LIMIT_W,
    parameter int MW = MAP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          active,
    input  logic [MW-1:0] done_map,
    input  logic [LW-1:0] limit,
    input  logic          limit_wr,
    output logic [LW-1:0] count,
    output logic          fire
);
    typedef struct packed {
        logic [LW-1:0] cnt;
        logic [MW-1:0] map;
    } cnt_t;

    cnt_t st_d, st_q;
    logic restart;
    logic qual;

    always_comb begin
        st_d     = st_q;
        st_d.map = done_map;
        restart  = limit_wr || (|(done_map & ~st_q.map));
        qual     = tick && active && (done_map == '0) &&
                   (limit != '0) && (st_q.cnt != limit);
        fire     = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (qual) begin
            st_d.cnt = st_q.cnt + 1'b1;
            fire     = (st_q.cnt + 1'b1) == limit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/nak_watchdog.sv
module nak_watchdog
    import nak_wd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LIMIT_W,
    parameter int MW = MAP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          tick_1ms,
    input  logic [MW-1:0] done_map,
    input  logic          xfer_active,
    output logic          irq
);
    logic [LW-1:0] limit_w;
    logic [LW-1:0] count_w;
    logic          limit_wr_w;
    logic          fire_w;
    logic          flag_w;

    nak_wd_regs #(.DW(DW), .LW(LW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .fire    (fire_w),
        .rd_data (rd_data),
        .limit   (limit_w),
        .limit_wr(limit_wr_w),
        .flag    (flag_w)
    );

    nak_wd_counter #(.LW(LW), .MW(MW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1ms),
        .active  (xfer_active),
        .done_map(done_map),
        .limit   (limit_w),
        .limit_wr(limit_wr_w),
        .count   (count_w),
        .fire    (fire_w)
    );

    assign irq = flag_w;
endmodule

// File: rtl/nak_watchdog_chk.sv
module nak_watchdog_chk
    import nak_wd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LIMIT_W,
    parameter int MW = MAP_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          addr,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] rd_data,
    input logic          tick_1ms,
    input logic [MW-1:0] done_map,
    input logic          xfer_active,
    input logic          irq,
    input logic [LW-1:0] limit_w,
    input logic [LW-1:0] count_w
);
    logic clr_req;
    assign clr_req = wr_en && addr && wr_data[FLAG_BIT];

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr_req |=> irq); // R8
    AST_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && !(tick_1ms && xfer_active) |=> !irq); // R3
    AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && (done_map != '0) |=> !irq); // R4
    AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && (limit_w == '0) |=> !irq); // R5
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_w <= limit_w); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DW-1:LW] == '0); // R2
endmodule

bind nak_watchdog nak_watchdog_chk #(.DW(DW), .LW(LW), .MW(MW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .tick_1ms   (tick_1ms),
    .done_map   (done_map),
    .xfer_active(xfer_active),
    .irq        (irq),
    .limit_w    (limit_w),
    .count_w    (count_w)
);

// File: tb/test_nak_watchdog.sv
`timescale 1ns/1ps
module test_nak_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        tick_1ms = 1'b0;
    logic [31:0] done_map = '0;
    logic        xfer_active = 1'b0;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    nak_watchdog i_nak_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .tick_1ms(tick_1ms),
        .done_map(done_map), .xfer_active(xfer_active), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_1ms = 1'b1;
            @(negedge clk);
            tick_1ms = 1'b0;
        end
    endtask

    task automatic clear_flag();
        wr(1'b1, 16'h0001);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got 0x0000 expected 0x0001");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(1'b0, v); chk("R1 limit", v, 16'h0001);
        rd(1'b1, v); chk("R1 status", v, 16'h0000);
        chk("R1 irq", {15'b0, irq}, 16'h0000);

        // R2 reserved bits
        wr(1'b0, 16'hAB37);
        rd(1'b0, v); chk("R2 limit readback", v, 16'h0037);

        // R3 sweep of limits: fires on exactly the N-th qualifying tick
        xfer_active = 1'b1;
        for (int lim = 1; lim <= 24; lim++) begin
            wr(1'b0, 16'(lim));
            clear_flag();
            ticks(lim - 1);
            chk($sformatf("R3 no early fire lim=%0d", lim), {15'b0, irq}, 16'h0000);
            ticks(1);
            chk($sformatf("R3 fire lim=%0d", lim), {15'b0, irq}, 16'h0001);
        end
        wr(1'b0, 16'd255);
        clear_flag();
        ticks(254);
        chk("R3 lim=255 early", {15'b0, irq}, 16'h0000);
        ticks(1);
        chk("R3 lim=255 fire", {15'b0, irq}, 16'h0001);
        rd(1'b1, v); chk("R8 status shows flag", v, 16'h0001);

        // R8 write 0 keeps, write 1 clears
        wr(1'b1, 16'hFFFE);
        chk("R8 write0 keeps", {15'b0, irq}, 16'h0001);
        clear_flag();
        chk("R8 write1 clears", {15'b0, irq}, 16'h0000);

        // R9 saturation after firing
        ticks(300);
        chk("R9 no refire", {15'b0, irq}, 16'h0000);

        // R3 inactive ticks ignored
        wr(1'b0, 16'd3);
        xfer_active = 1'b0;
        ticks(10);
        chk("R3 inactive", {15'b0, irq}, 16'h0000);
        xfer_active = 1'b1;
        ticks(2);
        chk("R3 active resumes early", {15'b0, irq}, 16'h0000);
        ticks(1);
        chk("R3 active resumes fire", {15'b0, irq}, 16'h0001);
        clear_flag();

        // R4 + R6 done map blocks and restarts
        wr(1'b0, 16'd4);
        ticks(2);
        @(negedge clk); done_map = 32'h0000_0100;
        ticks(8);
        chk("R4 done blocks", {15'b0, irq}, 16'h0000);
        @(negedge clk); done_map = '0;
        ticks(3);
        chk("R6 restart early", {15'b0, irq}, 16'h0000);
        ticks(1);
        chk("R6 restart fire", {15'b0, irq}, 16'h0001);
        clear_flag();
        wr(1'b0, 16'd3);
        ticks(2);
        @(negedge clk); done_map = 32'h8000_0000;
        @(negedge clk); done_map = '0;
        ticks(2);
        chk("R6 pulse restart early", {15'b0, irq}, 16'h0000);
        ticks(1);
        chk("R6 pulse restart fire", {15'b0, irq}, 16'h0001);
        clear_flag();

        // R7 write restarts, including same cycle as a tick
        wr(1'b0, 16'd4);
        ticks(3);
        wr(1'b0, 16'd4);
        ticks(3);
        chk("R7 rewrite early", {15'b0, irq}, 16'h0000);
        ticks(1);
        chk("R7 rewrite fire", {15'b0, irq}, 16'h0001);
        clear_flag();
        wr(1'b0, 16'd2);
        ticks(1);
        @(negedge clk);
        wr_en = 1'b1; addr = 1'b0; wr_data = 16'd2; tick_1ms = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1ms = 1'b0;
        ticks(1);
        chk("R7 write beats tick", {15'b0, irq}, 16'h0000);
        ticks(1);
        chk("R7 write beats tick fire", {15'b0, irq}, 16'h0001);

        // R8 set wins over clear in the same cycle
        wr(1'b0, 16'd1);
        @(negedge clk);
        wr_en = 1'b1; addr = 1'b1; wr_data = 16'h0001; tick_1ms = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1ms = 1'b0;
        chk("R8 set beats clear", {15'b0, irq}, 16'h0001);
        clear_flag();

        // R5 zero limit disables
        wr(1'b0, 16'h0000);
        rd(1'b0, v); chk("R5 limit zero read", v, 16'h0000);
        ticks(40);
        chk("R5 disabled", {15'b0, irq}, 16'h0000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule